// File: doc/BRIEF.md
# Pipelined Burst Static RAM

This block is a synchronous static RAM with a registered read path and a four-beat burst address generator. The data path is split into byte lanes (four lanes of eight bits by default), and the storage is a small register array. Address, control and write data are captured on the rising clock edge. Each edge is decoded as one of these cycle types: start of an access, continuation of a burst, wait state, or deselect. Read data passes through an output register. The output drive enable tells the surrounding pad logic when to drive the bus.

There are two address strobes. The processor strobe always starts with a read, whatever the write enables say. The controller strobe performs either a read or a write at the new address, as the write enables select. Once a burst is running, every edge that has no strobe continues it. An advance input steps the interleaved burst counter. Leaving advance high holds the address, which gives a wait state. A snooze input freezes the block. Stored data is kept, but accesses are ignored and the running burst is dropped.

Top module: `pbsram_core`

## Requirements
- R1: After reset, `drive_o` is low and no burst is running, so an edge with no strobe performs no access.
- R2: An access is a write when `glob_wr_n` is low, or when `byte_wr_n` is low and at least one bit of `lane_wr_n` is low. In every other case the access is a read.
- R3: With `glob_wr_n` low, a write updates all lanes, whatever `byte_wr_n` and `lane_wr_n` are.
- R4: With `glob_wr_n` high, bit k of `lane_wr_n` (active low) enables write data bits [8k+7:8k]. Lanes not enabled keep their old contents.
- R5: A processor strobe taken with `sel_a_n` low always reads the new address and ignores the write enables. The next edge with no strobe and `adv_n` high writes to that same loaded address when the write enables ask for it.
- R6: A controller strobe with `sel_a_n` low, `sel_b_n` low and `sel_c` high accesses the new address, reading or writing as R2 decides. If any of those three enables is inactive, the strobe deselects the block, and `drive_o` is low after that edge.
- R7: The processor strobe is ignored while `sel_a_n` is high. When it is taken with `sel_b_n` high or `sel_c` low, it deselects the block.
- R8: A read sampled at a clock edge places the word on `rdata_o` at that edge. `drive_o` is then high until the next edge, provided `oe_n` and `snooze` are low.
- R9: An edge with no strobe and `adv_n` low steps the beat count. The low two address bits become the start offset XOR the beat count, the upper bits stay fixed, and the sequence wraps after four beats.
- R10: An edge with no strobe and `adv_n` high during a burst accesses the same address again (wait state).
- R11: `oe_n` gates `drive_o` without a clock. After a write access, `drive_o` stays low.
- R12: While `snooze` is high at an edge, no access takes place, memory contents and `rdata_o` are held, and the burst is dropped. After `snooze` is released, nothing is accessed until a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addr_i | input | ADDR_W | External word address |
| sel_a_n | input | 1 | Chip enable, active low; also qualifies the processor strobe |
| sel_b_n | input | 1 | Chip enable, active low |
| sel_c | input | 1 | Chip enable, active high |
| strobe_proc_n | input | 1 | Processor address strobe, active low, forces a read |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high gives a wait state |
| glob_wr_n | input | 1 | Global write, active low, writes all lanes |
| byte_wr_n | input | 1 | Byte-write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Sleep with data retention, active high |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Registered read data |
| drive_o | output | 1 | Output drive enable for the data pads |

## Verification
The embedded assertions check these properties on every cycle:
- a taken processor strobe never raises a lane write;
- a global write never enables only some lanes;
- the cycle after a write or a deselect never drives the bus;
- snooze freezes the read register;
- the burst address keeps its upper bits, and repeats itself in a wait state.

Only the bench scenarios can show the rest: the actual data values stored through each lane mask, the interleaved order and wrap across all four beats, the delayed write after a processor strobe, and that no access happens after snooze until a new strobe arrives.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   // interleaved beat order: start offset XOR beat count
   function automatic logic [1:0] beat_offset(input logic [1:0] start, input logic [1:0] beat);
      return start ^ beat;
   endfunction

endpackage

// File: rtl/pbsram_decode.sv
module pbsram_decode
   import pbsram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             snooze,
   input  logic             act_q,
   input  logic             sel_a_n,
   input  logic             sel_b_n,
   input  logic             sel_c,
   input  logic             strobe_proc_n,
   input  logic             strobe_ctrl_n,
   input  logic             glob_wr_n,
   input  logic             byte_wr_n,
   input  logic [LANES-1:0] lane_wr_n,
   output logic             load,
   output logic             step,
   output logic             act_nxt,
   output acc_e             acc,
   output logic [LANES-1:0] lane_we
);

   logic wr_req;
   logic all_en;
   logic proc_take;

   assign wr_req    = !glob_wr_n || (!byte_wr_n && !(&lane_wr_n));
   assign all_en    = !sel_a_n && !sel_b_n && sel_c;
   assign proc_take = !strobe_proc_n && !sel_a_n;

   always_comb begin
      load    = 1'b0;
      step    = 1'b0;
      act_nxt = act_q;
      acc     = ACC_NONE;
      if (snooze) begin
         act_nxt = 1'b0;
      end else if (proc_take) begin
         load    = 1'b1;
         act_nxt = all_en;
         acc     = all_en ? ACC_READ : ACC_NONE;
      end else if (!strobe_ctrl_n) begin
         load    = 1'b1;
         act_nxt = all_en;
         if (all_en) acc = wr_req ? ACC_WRITE : ACC_READ;
      end else if (act_q) begin
         step = 1'b1;
         acc  = wr_req ? ACC_WRITE : ACC_READ;
      end
   end

   always_comb begin
      lane_we = '0;
      if (acc == ACC_WRITE) begin
         if (!glob_wr_n) lane_we = '1;
         else            lane_we = ~lane_wr_n;
      end
   end

endmodule

// File: rtl/pbsram_burst.sv
module pbsram_burst #(
   parameter int ADDR_W = 6,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] acc_addr
);

   localparam int HI_W = ADDR_W - BEAT_W;

   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] beat_nxt;

   assign beat_nxt = adv_n ? beat_q : beat_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
      end else if (load) begin
         base_q <= addr_i;
         beat_q <= '0;
      end else if (step && !adv_n) begin
         beat_q <= beat_nxt;
      end
   end

   generate
      if (BEAT_W == 2) begin : g_pkg_order
         assign acc_addr = load ? addr_i
                         : {base_q[ADDR_W-1 -: HI_W], pbsram_pkg::beat_offset(base_q[1:0], beat_nxt)};
      end else begin : g_gen_order
         assign acc_addr = load ? addr_i
                         : {base_q[ADDR_W-1 -: HI_W], base_q[BEAT_W-1:0] ^ beat_nxt};
      end
   endgenerate

   // R10: a wait state repeats the previous access address
   assert_wait_repeats_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (step && adv_n && $past(load || step)) |-> (acc_addr == $past(acc_addr)));

   // R9: upper address bits never change inside a burst
   assert_upper_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && $past(load || step)) |-> (acc_addr[ADDR_W-1 -: HI_W] == $past(acc_addr[ADDR_W-1 -: HI_W])));

endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        lane_we,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata_q
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];
         logic [LANE_W-1:0] q;

         always_ff @(posedge clk) begin
            if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
         end

         always_ff @(posedge clk) begin
            if (!rst_n)     q <= '0;
            else if (rd_en) q <= mem[addr];
         end

         assign rdata_q[g*LANE_W +: LANE_W] = q;
      end
   endgenerate

   // reads and writes never share an edge
   assert_rd_wr_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (lane_we == '0));

endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
   import pbsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int BEAT_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    sel_a_n,
   input  logic                    sel_b_n,
   input  logic                    sel_c,
   input  logic                    strobe_proc_n,
   input  logic                    strobe_ctrl_n,
   input  logic                    adv_n,
   input  logic                    glob_wr_n,
   input  logic                    byte_wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    oe_n,
   input  logic                    snooze,
   input  logic [LANES*LANE_W-1:0] wdata_i,
   output logic [LANES*LANE_W-1:0] rdata_o,
   output logic                    drive_o
);

   localparam int DATA_W = LANES * LANE_W;

   generate
      if (ADDR_W <= BEAT_W) begin : g_bad_addr
         $error("pbsram_core: ADDR_W must exceed BEAT_W");
      end
      if (BEAT_W < 1) begin : g_bad_beat
         $error("pbsram_core: BEAT_W must be at least 1");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("pbsram_core: LANES and LANE_W must be positive");
      end
   endgenerate

   logic              act_q;
   logic              rdv_q;
   logic              load;
   logic              step;
   logic              act_nxt;
   acc_e              acc;
   logic [LANES-1:0]  lane_we;
   logic [ADDR_W-1:0] acc_addr;

   pbsram_decode #(.LANES(LANES)) u_decode (
      .snooze        (snooze),
      .act_q         (act_q),
      .sel_a_n       (sel_a_n),
      .sel_b_n       (sel_b_n),
      .sel_c         (sel_c),
      .strobe_proc_n (strobe_proc_n),
      .strobe_ctrl_n (strobe_ctrl_n),
      .glob_wr_n     (glob_wr_n),
      .byte_wr_n     (byte_wr_n),
      .lane_wr_n     (lane_wr_n),
      .load          (load),
      .step          (step),
      .act_nxt       (act_nxt),
      .acc           (acc),
      .lane_we       (lane_we)
   );

   pbsram_burst #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .adv_n    (adv_n),
      .addr_i   (addr_i),
      .acc_addr (acc_addr)
   );

   pbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_we (lane_we),
      .rd_en   (acc == ACC_READ),
      .addr    (acc_addr),
      .wdata   (wdata_i),
      .rdata_q (rdata_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         rdv_q <= 1'b0;
      end else begin
         act_q <= act_nxt;
         rdv_q <= (acc == ACC_READ);
      end
   end

   assign drive_o = rdv_q && !oe_n && !snooze;

   // R5: a taken processor strobe never writes
   assert_proc_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!snooze && !strobe_proc_n && !sel_a_n) |-> (lane_we == '0));

   // R3: a global write touches every lane or none
   assert_global_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_wr_n && (lane_we != '0)) |-> (&lane_we));

   // R6: a controller strobe that is not fully enabled leaves the bus undriven
   assert_deselect_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!snooze && (strobe_proc_n || sel_a_n) && !strobe_ctrl_n && (sel_a_n || sel_b_n || !sel_c)) |=> !drive_o);

   // R11: the cycle after a write never drives the bus
   assert_write_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_we != '0) |=> !drive_o);

   // R12: snooze freezes the read register and the drive
   assert_snooze_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      snooze |=> ($stable(rdata_o) && !drive_o));

endmodule

// File: tb/pbsram_core_bench.sv
`timescale 1ns/1ps
module pbsram_core_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  addr;
   logic        sel_a_n, sel_b_n, sel_c;
   logic        sp_n, sc_n, adv_n;
   logic        gw_n, bw_n;
   logic [3:0]  lane_n;
   logic        oe_n, snooze;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        drive;

   int    tests = 0;
   int    fails = 0;
   string tag   = "R1";
   bit    done  = 1'b0;

   always #2.5 clk = ~clk;

   pbsram_core u_pbsram_core (
      .clk (clk), .rst_n (rst_n), .addr_i (addr),
      .sel_a_n (sel_a_n), .sel_b_n (sel_b_n), .sel_c (sel_c),
      .strobe_proc_n (sp_n), .strobe_ctrl_n (sc_n), .adv_n (adv_n),
      .glob_wr_n (gw_n), .byte_wr_n (bw_n), .lane_wr_n (lane_n),
      .oe_n (oe_n), .snooze (snooze), .wdata_i (wdata),
      .rdata_o (rdata), .drive_o (drive)
   );

   // behavioural reference model
   logic [31:0] mm [64];
   bit          m_act, m_rdv;
   logic [31:0] m_dout;
   int          m_base, m_beat;

   task automatic m_access(input int a, input bit wr);
      if (wr) begin
         for (int i = 0; i < 4; i++)
            if (!gw_n || !lane_n[i]) mm[a][i*8 +: 8] = wdata[i*8 +: 8];
         m_rdv = 1'b0;
      end else begin
         m_dout = mm[a];
         m_rdv  = 1'b1;
      end
   endtask

   always @(posedge clk) begin
      bit wr, en;
      wr = !gw_n || (!bw_n && lane_n != 4'hF);
      en = !sel_a_n && !sel_b_n && sel_c;
      if (!rst_n) begin
         m_act = 0; m_rdv = 0; m_dout = 0;
      end else if (snooze) begin
         m_act = 0; m_rdv = 0;
      end else if (!sp_n && !sel_a_n) begin
         m_base = addr; m_beat = 0; m_act = en;
         if (en) m_access(addr, 1'b0); else m_rdv = 0;
      end else if (!sc_n) begin
         m_base = addr; m_beat = 0; m_act = en;
         if (en) m_access(addr, wr); else m_rdv = 0;
      end else if (m_act) begin
         if (!adv_n) m_beat = (m_beat + 1) % 4;
         m_access((m_base & 60) | ((m_base & 3) ^ m_beat), wr);
      end else begin
         m_rdv = 0;
      end
   end

   task automatic compare();
      bit exp_drv;
      exp_drv = m_rdv && !oe_n && !snooze;
      tests++;
      if (drive !== exp_drv) begin
         fails++;
         $display("FAIL %s drive act=%0b exp=%0b", tag, drive, exp_drv);
      end
      if (exp_drv) begin
         tests++;
         if (rdata !== m_dout) begin
            fails++;
            $display("FAIL %s rdata act=%h exp=%h", tag, rdata, m_dout);
         end
      end
   endtask

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s value act=%h exp=%h", t, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
      compare();
   endtask

   task automatic idle();
      sp_n = 1; sc_n = 1; adv_n = 1; gw_n = 1; bw_n = 1; lane_n = 4'hF;
      sel_a_n = 0; sel_b_n = 0; sel_c = 1;
   endtask

   task automatic ctrl(input int a, input bit g, input bit b, input logic [3:0] l, input logic [31:0] d);
      idle();
      sc_n = 0; addr = a[5:0]; gw_n = g; bw_n = b; lane_n = l; wdata = d;
      cyc();
      idle();
   endtask

   task automatic cont(input bit adv, input bit g, input logic [31:0] d);
      idle();
      adv_n = adv; gw_n = g; wdata = d;
      cyc();
      idle();
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mm[i] = '0;
      idle(); addr = 0; wdata = 0; oe_n = 0; snooze = 0; rst_n = 0;
      repeat (3) cyc();
      rst_n = 1;
      tag = "R1"; cyc();
      chk("R1", {31'd0, drive}, 32'd0);

      tag = "R3"; ctrl(8, 0, 1, 4'hF, 32'hA5A5_0001);
      tag = "R8"; ctrl(8, 1, 1, 4'hF, 32'h0);
      chk("R8", rdata, 32'hA5A5_0001);
      chk("R8", {31'd0, drive}, 32'd1);

      tag = "R4"; ctrl(8, 1, 0, 4'b1101, 32'h1122_3344);
      ctrl(8, 1, 1, 4'hF, 32'h0);
      chk("R4", rdata, 32'hA5A5_3301);

      tag = "R2"; ctrl(8, 1, 1, 4'h0, 32'hFFFF_FFFF);
      chk("R2", rdata, 32'hA5A5_3301);
      chk("R2", {31'd0, drive}, 32'd1);

      tag = "R5"; ctrl(9, 0, 1, 4'hF, 32'h0000_0009);
      idle(); sp_n = 0; addr = 9; gw_n = 0; wdata = 32'hDEAD_BEEF; cyc(); idle();
      chk("R5", rdata, 32'h0000_0009);
      cont(1, 0, 32'hCAFE_F00D);
      chk("R5", {31'd0, drive}, 32'd0);
      ctrl(9, 1, 1, 4'hF, 32'h0);
      chk("R5", rdata, 32'hCAFE_F00D);

      tag = "R9";
      for (int i = 16; i < 20; i++) ctrl(i, 0, 1, 4'hF, 32'h100 + i);
      ctrl(18, 1, 1, 4'hF, 32'h0);
      chk("R9", rdata, 32'h112);
      cont(0, 1, 0); chk("R9", rdata, 32'h113);
      cont(0, 1, 0); chk("R9", rdata, 32'h110);
      cont(0, 1, 0); chk("R9", rdata, 32'h111);
      cont(0, 1, 0); chk("R9", rdata, 32'h112);
      tag = "R10"; cont(1, 1, 0); chk("R10", rdata, 32'h112);
      cont(1, 1, 0); chk("R10", rdata, 32'h112);

      tag = "R7"; idle(); sp_n = 0; sel_a_n = 1; adv_n = 0; cyc(); idle();
      chk("R7", rdata, 32'h113);
      idle(); sp_n = 0; sel_c = 0; addr = 8; cyc(); idle();
      chk("R7", {31'd0, drive}, 32'd0);

      tag = "R6"; ctrl(8, 1, 1, 4'hF, 0);
      chk("R6", {31'd0, drive}, 32'd1);
      idle(); sc_n = 0; sel_c = 0; addr = 9; cyc(); idle();
      chk("R6", {31'd0, drive}, 32'd0);
      cont(1, 1, 0);
      chk("R6", {31'd0, drive}, 32'd0);

      tag = "R11"; ctrl(8, 1, 1, 4'hF, 0);
      oe_n = 1; #1; compare(); chk("R11", {31'd0, drive}, 32'd0);
      oe_n = 0; #1; compare(); chk("R11", {31'd0, drive}, 32'd1);
      cont(1, 0, 32'h0000_0088);
      chk("R11", {31'd0, drive}, 32'd0);
      ctrl(8, 1, 1, 4'hF, 0);
      chk("R11", rdata, 32'h0000_0088);

      tag = "R12"; ctrl(16, 1, 1, 4'hF, 0);
      chk("R12", rdata, 32'h110);
      snooze = 1; idle(); sc_n = 0; addr = 16; gw_n = 0; wdata = 32'hBAD; cyc(); idle();
      chk("R12", {31'd0, drive}, 32'd0);
      cyc(); cyc();
      chk("R12", rdata, 32'h110);
      snooze = 0; cont(0, 0, 32'hBAD);
      chk("R12", {31'd0, drive}, 32'd0);
      ctrl(16, 1, 1, 4'hF, 0);
      chk("R12", rdata, 32'h110);
      ctrl(17, 1, 1, 4'hF, 0);
      chk("R12", rdata, 32'h111);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule